// File: doc/BRIEF.md
# Page Protection and Reference Checker

This block decides whether one memory access may proceed against a translated page. The inputs are the protection code of the page entry, the access key of the segment, the no-execute and guarded bits of the entry, its current referenced and changed bits, and the kind of access. The block returns three things. The first is the read/write/execute permission that the page grants. The second is a fault flag, raised when the access asks for a right the page does not give. The third is the updated referenced and changed bits, with a strobe that says the entry has to be written back to the page table.

Write permission is held back on purpose. While the changed bit is clear, the returned mask shows the page as not writable, unless the access itself is a granted write that sets the bit. A later write that hits a cached copy of the mask therefore traps, and that trap gives the changed bit its chance to be recorded. The outputs are registered once per valid input strobe. A separate unit that walks the page table reads the entries and stores them back.

Top module: `pp_prot_chk`

## Requirements
- R1: The 3-bit protection code is `{in_pp_hi, in_pp_lo}`, where `in_pp_hi` is the most significant bit. Codes 6 and 2 differ only in `in_pp_hi` and must decode differently.
- R2: With `in_key` = 0, codes 0, 1 and 2 grant read and write, codes 3 and 6 grant read only, and codes 4, 5 and 7 grant neither. `out_perm` bit 0 is read, bit 1 is write and bit 2 is execute.
- R3: With `in_key` = 1, code 2 grants read and write, codes 1 and 3 grant read only, and codes 0, 4, 5, 6 and 7 grant neither.
- R4: Execute permission (`out_perm[2]`) is 1 exactly when both `in_noexec` and `in_guard` are 0, whatever the key and code.
- R5: `in_acc` encodes the access: 2'b10 is execute, 2'b01 is write, and 2'b00 and 2'b11 are read. `out_fault` is 1 when the page does not grant the right that the access asks for. This test uses the mask as it is before the changed-bit rule in R8 is applied.
- R6: `out_ref` is always 1. When `in_ref` was 0, `out_wb` is 1.
- R7: When `in_chg` is 0 and the access is a write that does not fault, `out_chg` is 1 and `out_wb` is 1. In every other case `out_chg` equals `in_chg`. `out_wb` is 0 when neither R6 nor R7 asks for a write-back.
- R8: When `out_chg` is 0, `out_perm[1]` is 0, even if the protection code grants write.
- R9: All outputs update in the cycle after a cycle in which `in_valid` is 1, and `out_valid` is 1 for exactly that one cycle. When `in_valid` is 0, the data outputs keep their values.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| in_valid | input | 1 | Inputs valid this cycle |
| in_key | input | 1 | Segment access key |
| in_pp_lo | input | 2 | Low two bits of the protection code |
| in_pp_hi | input | 1 | High bit of the protection code |
| in_noexec | input | 1 | Entry no-execute bit |
| in_guard | input | 1 | Entry guarded bit |
| in_ref | input | 1 | Current referenced bit |
| in_chg | input | 1 | Current changed bit |
| in_acc | input | 2 | Access kind (see R5) |
| out_valid | output | 1 | Result valid strobe |
| out_perm | output | 3 | Granted mask {exec, write, read} |
| out_fault | output | 1 | Access violation |
| out_ref | output | 1 | Updated referenced bit |
| out_chg | output | 1 | Updated changed bit |
| out_wb | output | 1 | Entry must be stored back |

## Verification
The bench instantiates the block twice. One copy has `DEC_STYLE` = 0, the constant-table decoder. The other has `DEC_STYLE` = 1, the case-statement decoder. Both copies get the same stimulus and are compared against the same expected values. The input space is only 1024 combinations, so both decoder variants are driven through every combination of key, code, no-execute, guarded, referenced, changed and access kind. This exercises every key/code pair together with every changed-bit and write-back interaction. Directed steps then cover reset, the case where outputs are held while no input is valid, and the code-6 versus code-2 split on the high protection bit.

// File: rtl/pp_chk_pkg.sv
package pp_chk_pkg;

   // protection code width and access-kind width
   localparam int PP_W   = 3;
   localparam int ACC_W  = 2;
   localparam int PERM_W = 3;

   // access kinds; any other code is treated as a read
   localparam logic [ACC_W-1:0] ACC_READ  = 2'b00;
   localparam logic [ACC_W-1:0] ACC_WRITE = 2'b01;
   localparam logic [ACC_W-1:0] ACC_EXEC  = 2'b10;

   // permission bit positions inside the mask
   localparam int PERM_RD = 0;
   localparam int PERM_WR = 1;
   localparam int PERM_EX = 2;

   typedef struct packed {
      logic ex;
      logic wr;
      logic rd;
   } perm_t;

   typedef struct packed {
      logic  fault;
      perm_t perm;
      logic  ref_b;
      logic  chg_b;
      logic  wb;
   } chk_res_t;

endpackage

// File: rtl/pp_perm_dec.sv
module pp_perm_dec
   import pp_chk_pkg::*;
#(
   parameter int DEC_STYLE = 0
) (
   input  logic            key,
   input  logic [PP_W-1:0] pp,
   output logic            rd,
   output logic            wr
);

   localparam int IDX_W = PP_W + 1;
   localparam int LUT_N = 1 << IDX_W;

   // index = {key, pp}; key 0 half in bits 7..0, key 1 half in bits 15..8
   localparam logic [LUT_N-1:0] RD_LUT = 16'h0E4F;
   localparam logic [LUT_N-1:0] WR_LUT = 16'h0407;

   initial begin
      if (PP_W != 3) $error("pp_perm_dec: PP_W must be 3");
   end

   generate
      if (DEC_STYLE == 0) begin : g_lut
         logic [IDX_W-1:0] idx;
         assign idx = {key, pp};
         assign rd  = RD_LUT[idx];
         assign wr  = WR_LUT[idx];
      end else if (DEC_STYLE == 1) begin : g_case
         always_comb begin
            rd = 1'b0;
            wr = 1'b0;
            if (!key) begin
               case (pp)
                  3'd0, 3'd1, 3'd2: begin rd = 1'b1; wr = 1'b1; end
                  3'd3, 3'd6:       begin rd = 1'b1; end
                  default:          begin rd = 1'b0; wr = 1'b0; end
               endcase
            end else begin
               case (pp)
                  3'd2:       begin rd = 1'b1; wr = 1'b1; end
                  3'd1, 3'd3: begin rd = 1'b1; end
                  default:    begin rd = 1'b0; wr = 1'b0; end
               endcase
            end
         end
      end else begin : g_bad
         initial $error("pp_perm_dec: DEC_STYLE must be 0 or 1");
         assign rd = 1'b0;
         assign wr = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/pp_rc_upd.sv
module pp_rc_upd
   import pp_chk_pkg::*;
(
   input  logic             ref_in,
   input  logic             chg_in,
   input  logic [ACC_W-1:0] acc,
   input  logic             granted,
   output logic             ref_out,
   output logic             chg_out,
   output logic             wb,
   output logic             hide_wr
);

   logic set_chg;

   always_comb begin
      set_chg = !chg_in && (acc == ACC_WRITE) && granted;
      ref_out = 1'b1;
      chg_out = chg_in | set_chg;
      wb      = !ref_in | set_chg;
      hide_wr = !chg_out;
   end

endmodule

// File: rtl/pp_prot_chk.sv
module pp_prot_chk
   import pp_chk_pkg::*;
#(
   parameter int DEC_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_key,
   input  logic [1:0]        in_pp_lo,
   input  logic              in_pp_hi,
   input  logic              in_noexec,
   input  logic              in_guard,
   input  logic              in_ref,
   input  logic              in_chg,
   input  logic [ACC_W-1:0]  in_acc,
   output logic              out_valid,
   output logic [PERM_W-1:0] out_perm,
   output logic              out_fault,
   output logic              out_ref,
   output logic              out_chg,
   output logic              out_wb
);

   initial begin
      if (PERM_W != 3) $error("pp_prot_chk: PERM_W must be 3");
      if (ACC_W  != 2) $error("pp_prot_chk: ACC_W must be 2");
   end

   logic [PP_W-1:0] pp;
   logic            dec_rd, dec_wr;
   perm_t           raw;
   logic            need;
   logic            u_ref, u_chg, u_wb, u_hide;
   chk_res_t        nxt, cur;

   assign pp = {in_pp_hi, in_pp_lo};

   pp_perm_dec #(.DEC_STYLE(DEC_STYLE)) i_dec (
      .key (in_key),
      .pp  (pp),
      .rd  (dec_rd),
      .wr  (dec_wr)
   );

   always_comb begin
      raw.rd = dec_rd;
      raw.wr = dec_wr;
      raw.ex = !(in_noexec | in_guard);
      case (in_acc)
         ACC_EXEC:  need = raw.ex;
         ACC_WRITE: need = raw.wr;
         default:   need = raw.rd;
      endcase
   end

   pp_rc_upd i_rc (
      .ref_in  (in_ref),
      .chg_in  (in_chg),
      .acc     (in_acc),
      .granted (need),
      .ref_out (u_ref),
      .chg_out (u_chg),
      .wb      (u_wb),
      .hide_wr (u_hide)
   );

   always_comb begin
      nxt.fault   = !need;
      nxt.perm.rd = raw.rd;
      nxt.perm.wr = raw.wr & !u_hide;
      nxt.perm.ex = raw.ex;
      nxt.ref_b   = u_ref;
      nxt.chg_b   = u_chg;
      nxt.wb      = u_wb;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         cur       <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) cur <= nxt;
      end
   end

   assign out_perm  = {cur.perm.ex, cur.perm.wr, cur.perm.rd};
   assign out_fault = cur.fault;
   assign out_ref   = cur.ref_b;
   assign out_chg   = cur.chg_b;
   assign out_wb    = cur.wb;

   // R9
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R9
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_perm) && $stable(out_fault) && $stable(out_wb)
                     && $stable(out_chg) && $stable(out_ref)));
   // R8
   hide_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_chg) |-> !out_perm[PERM_WR]);
   // R6
   ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_ref);
   // R4
   exec_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_noexec || in_guard)) |=> !out_perm[PERM_EX]);
   // R7
   chg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_acc == ACC_WRITE) |=> (out_fault || out_chg));

endmodule

// File: tb/test_pp_prot_chk.sv
module test_pp_prot_chk;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0, in_key = 1'b0, in_pp_hi = 1'b0;
   logic [1:0] in_pp_lo = 2'b00, in_acc = 2'b00;
   logic       in_noexec = 1'b0, in_guard = 1'b0, in_ref = 1'b0, in_chg = 1'b0;

   logic       v0, f0, r0, c0, w0, v1, f1, r1o, c1, w1;
   logic [2:0] p0, p1;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   pp_prot_chk #(.DEC_STYLE(0)) i_pp_prot_chk (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_key(in_key),
      .in_pp_lo(in_pp_lo), .in_pp_hi(in_pp_hi), .in_noexec(in_noexec),
      .in_guard(in_guard), .in_ref(in_ref), .in_chg(in_chg), .in_acc(in_acc),
      .out_valid(v0), .out_perm(p0), .out_fault(f0), .out_ref(r0),
      .out_chg(c0), .out_wb(w0));

   pp_prot_chk #(.DEC_STYLE(1)) i_pp_prot_chk_case (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_key(in_key),
      .in_pp_lo(in_pp_lo), .in_pp_hi(in_pp_hi), .in_noexec(in_noexec),
      .in_guard(in_guard), .in_ref(in_ref), .in_chg(in_chg), .in_acc(in_acc),
      .out_valid(v1), .out_perm(p1), .out_fault(f1), .out_ref(r1o),
      .out_chg(c1), .out_wb(w1));

   // stimulus {key, pp_hi, pp_lo[1:0], noexec, guard, ref, chg, acc[1:0]}
   // expected {perm[2:0] = ex,wr,rd, fault, ref, chg, wb}
   localparam int NV = 13;
   localparam logic [16:0] TBL [NV] = '{
      {10'b0_0_00_0_0_0_0_01, 7'b111_0_1_1_1},
      {10'b0_0_00_0_0_1_0_00, 7'b101_0_1_0_0},
      {10'b0_1_10_0_0_1_1_01, 7'b101_1_1_1_0},
      {10'b0_0_11_1_0_1_1_10, 7'b001_1_1_1_0},
      {10'b1_0_10_0_0_1_1_01, 7'b111_0_1_1_0},
      {10'b1_0_00_0_0_0_1_00, 7'b100_1_1_1_1},
      {10'b1_0_01_0_1_1_0_01, 7'b001_1_1_0_0},
      {10'b1_1_10_0_0_1_1_10, 7'b100_0_1_1_0},
      {10'b0_1_01_0_0_1_1_00, 7'b100_1_1_1_0},
      {10'b1_0_11_0_0_1_1_11, 7'b101_0_1_1_0},
      {10'b0_0_10_0_0_0_0_10, 7'b101_0_1_0_1},
      {10'b1_1_00_0_0_1_0_01, 7'b100_1_1_0_0},
      {10'b0_0_01_0_1_1_0_01, 7'b011_0_1_1_1}
   };

   function automatic logic [6:0] model(input logic [9:0] s);
      logic k, nx, g, rf, ch, rd, wr, ex, need, nc, wb;
      logic [2:0] pp;
      logic [1:0] a;
      k  = s[9]; pp = s[8:6]; nx = s[5]; g = s[4]; rf = s[3]; ch = s[2];
      a  = s[1:0];
      rd = 1'b0; wr = 1'b0;
      if (!k) begin
         rd = (pp <= 3'd3) || (pp == 3'd6);
         wr = (pp <= 3'd2);
      end else begin
         rd = (pp >= 3'd1) && (pp <= 3'd3);
         wr = (pp == 3'd2);
      end
      ex = !(nx || g);
      need = (a == 2'b10) ? ex : (a == 2'b01) ? wr : rd;
      nc = ch || (a == 2'b01 && need);
      wb = !rf || (!ch && a == 2'b01 && need);
      return {ex, wr & nc, rd, !need, 1'b1, nc, wb};
   endfunction

   task automatic one(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic cmp(input logic [9:0] s, input logic [6:0] e, input string src);
      one({src, " R9 valid"}, v0, 1'b1);
      one({src, s[9] ? " R3 read" : " R2 read"}, p0[0], e[4]);
      one({src, " R8 write mask"}, p0[1], e[5]);
      one({src, " R4 exec"}, p0[2], e[6]);
      one({src, " R5 fault"}, f0, e[3]);
      one({src, " R6 ref"}, r0, e[2]);
      one({src, " R7 chg"}, c0, e[1]);
      one({src, " R7 wb"}, w0, e[0]);
      one({src, " R2 R3 case-variant mask"}, (p1 == p0) && (f1 == f0), 1'b1);
      one({src, " R7 case-variant rc"}, {v1, r1o, c1, w1} == {v0, r0, c0, w0}, 1'b1);
   endtask

   task automatic apply(input logic [9:0] s);
      @(negedge clk);
      {in_key, in_pp_hi, in_pp_lo, in_noexec, in_guard, in_ref, in_chg, in_acc} = s;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      one("R10 reset valid", v0, 1'b0);
      one("R10 reset outputs", |{p0, f0, r0, c0, w0}, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         apply(TBL[i][16:7]);
         cmp(TBL[i][16:7], TBL[i][6:0], "table");
      end

      for (int s = 0; s < 1024; s++) begin
         apply(s[9:0]);
         cmp(s[9:0], model(s[9:0]), "sweep");
      end

      // R1: code 6 (hi=1, lo=2) read only versus code 2 read/write, key 0
      apply(10'b0_1_10_0_0_1_1_00);
      one("R1 code6 write", p0[1], 1'b0);
      apply(10'b0_0_10_0_0_1_1_00);
      one("R1 code2 write", p0[1], 1'b1);

      // R9: one-cycle valid pulse, outputs held while idle
      @(negedge clk);
      one("R9 valid pulse", v0, 1'b0);
      in_pp_hi = 1'b1; in_key = 1'b1; in_acc = 2'b10; in_chg = 1'b0;
      repeat (2) @(negedge clk);
      one("R9 hold perm", p0, 3'b111);
      one("R9 hold chg", c0, 1'b1);

      // R10: reset again mid-run clears outputs
      rst_n = 1'b0;
      @(negedge clk);
      one("R10 re-reset", |{v0, p0, f0, r0, c0, w0}, 1'b0);
      rst_n = 1'b1;
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule